// File: doc/BRIEF.md
# Integer Divide and Modulo Unit

A multi-cycle integer division engine for a 64-bit datapath. It divides signed or unsigned operands at word (32-bit) or doubleword (64-bit) width. It returns either the quotient or the remainder. It also supports an "extended" divide, in which the dividend is the A operand moved up by the operand width with zeros filled in below. A single restoring shift-subtract core produces one quotient bit per clock. The number of steps is 32, 64 or 128, depending on how wide the dividend is.

A request is presented with a one-cycle `start_i` together with the operation code and both operands. Those inputs are captured in that cycle and may change afterwards. When the answer is ready, `done_o` pulses for one cycle. `result_o` and `ovf_o` then hold their values until the next completion.

Every case with an undefined result is detected. These are:
- a zero divisor;
- the most negative value divided by minus one;
- an extended quotient that does not fit the target width.

In each of these cases the unit returns all zeros with the overflow flag set.

Top module: `intdiv_unit`

## Requirements
- R1: `op_i` bit 0 selects unsigned (1) or signed (0), bit 1 selects doubleword (1) or word (0), bit 2 selects modulo, and bit 3 selects extended divide. When bit 3 is set, bit 2 is ignored. A word divide uses A[31:0] and B[31:0]. Its quotient truncates toward zero and is returned in result[31:0], with result[63:32] zero.
- R2: A modulo returns the remainder, which takes the sign of the dividend. A signed word remainder is sign-extended from bit 31 to 64 bits. An unsigned word remainder is zero-extended.
- R3: A doubleword divide or modulo uses the full 64-bit A and B and returns a 64-bit result.
- R4: A zero divisor (B[31:0] for word operations, B for doubleword operations) gives result 0 with `ovf_o`=1, for every operation. A defined result always comes with `ovf_o`=0.
- R5: A signed divide or modulo of the most negative value by minus one gives result 0 with `ovf_o`=1, at both widths.
- R6: An extended word divide uses the dividend {A[31:0], 32 zeros}. In the signed form, the divisor is B[31:0] sign-extended and the dividend is taken as a signed 64-bit value. The result is undefined (0 with `ovf_o`=1) unless the quotient fits in 32 bits: signed range for the signed form, and A[31:0] < B[31:0] for the unsigned form.
- R7: An extended doubleword divide uses the 128-bit dividend {A, 64 zeros} and the divisor B. The result is undefined unless the quotient fits in 64 bits, using the signed range for the signed form.
- R8: `done_o` is a single-cycle pulse. It appears N+1 clock edges after the edge that accepts `start_i`. N is 32 for word divide and modulo, 64 for extended word or doubleword divide and modulo, and 128 for extended doubleword divide.
- R9: While a request is in progress, `start_i` and operand changes are ignored. `result_o` and `ovf_o` change only together with a `done_o` pulse.
- R10: After reset, `done_o`, `result_o` and `ovf_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse; accepted only when the unit is idle |
| op_i | input | 4 | Operation code (see R1) |
| a_i | input | 64 | Dividend operand A |
| b_i | input | 64 | Divisor operand B |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Quotient or remainder, 0 when undefined |
| ovf_o | output | 1 | Undefined-result flag |

## Verification
A wrong remainder or quotient bit inside the core appears only in `result_o`, and only when `done_o` pulses, 33, 65 or 129 edges after acceptance. For this reason, every request is compared against an exact wide-arithmetic model in the bench. A faulty iteration counter or finish flag instead shows up as a changed completion latency, or as a missing or repeated `done_o` pulse. Both are caught at the first affected request. Faulty sign or fit bookkeeping is exposed by the negative-operand cases, the most-negative-by-minus-one cases and the cases on the edge of the extended range. There the overflow flag or the sign of the result differs on that same `done_o` pulse.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

   // operation code bit positions
   localparam int OPB_UNS = 0;
   localparam int OPB_DW  = 1;
   localparam int OPB_MOD = 2;
   localparam int OPB_EXT = 3;

   typedef struct packed {
      logic uns;
      logic dw;
      logic md;
      logic ext;
   } div_op_t;

   typedef struct packed {
      div_op_t op;
      logic    dvd_neg;
      logic    dsr_neg;
      logic    dsr_zero;
   } div_ctx_t;

   function automatic div_op_t decode_op(input logic [3:0] code);
      div_op_t o;
      o.uns = code[OPB_UNS];
      o.dw  = code[OPB_DW];
      o.ext = code[OPB_EXT];
      o.md  = code[OPB_MOD] & ~code[OPB_EXT];
      return o;
   endfunction

endpackage

// File: rtl/intdiv_prep.sv
module intdiv_prep
   import intdiv_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  div_op_t               op_i,
   input  logic [XLEN-1:0]       a_i,
   input  logic [XLEN-1:0]       b_i,
   output logic [2*XLEN-1:0]     dvd_mag_o,
   output logic [XLEN-1:0]       dsr_mag_o,
   output logic                  dvd_neg_o,
   output logic                  dsr_neg_o,
   output logic                  dsr_zero_o,
   output logic [$clog2(2*XLEN+1)-1:0] iters_o
);
   localparam int DW = 2 * XLEN;
   localparam int HW = XLEN / 2;
   localparam int CW = $clog2(DW + 1);

   logic            sgn;
   logic [DW-1:0]   dvd_raw;
   logic [XLEN-1:0] dsr_raw;

   assign sgn = ~op_i.uns;

   always_comb begin
      if (op_i.ext && op_i.dw)
         dvd_raw = {a_i, {XLEN{1'b0}}};
      else if (op_i.ext)
         dvd_raw = {{XLEN{sgn & a_i[HW-1]}}, a_i[HW-1:0], {HW{1'b0}}};
      else if (op_i.dw)
         dvd_raw = {{XLEN{sgn & a_i[XLEN-1]}}, a_i};
      else
         dvd_raw = {{(DW-HW){sgn & a_i[HW-1]}}, a_i[HW-1:0]};

      if (op_i.dw)
         dsr_raw = b_i;
      else
         dsr_raw = {{HW{sgn & b_i[HW-1]}}, b_i[HW-1:0]};

      if (op_i.ext && op_i.dw)
         iters_o = CW'(DW);
      else if (op_i.ext || op_i.dw)
         iters_o = CW'(XLEN);
      else
         iters_o = CW'(HW);
   end

   assign dvd_neg_o  = sgn & dvd_raw[DW-1];
   assign dsr_neg_o  = sgn & dsr_raw[XLEN-1];
   assign dvd_mag_o  = dvd_neg_o ? (~dvd_raw + 1'b1) : dvd_raw;
   assign dsr_mag_o  = dsr_neg_o ? (~dsr_raw + 1'b1) : dsr_raw;
   assign dsr_zero_o = (dsr_raw == '0);

endmodule

// File: rtl/intdiv_core.sv
module intdiv_core #(
   parameter int XLEN = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_i,
   input  logic [$clog2(2*XLEN+1)-1:0] iters_i,
   input  logic [2*XLEN-1:0]           dvd_i,
   input  logic [XLEN-1:0]             dsr_i,
   output logic                        busy_o,
   output logic                        fin_o,
   output logic [2*XLEN-1:0]           quo_o,
   output logic [XLEN-1:0]             rem_o
);
   localparam int DW = 2 * XLEN;
   localparam int CW = $clog2(DW + 1);
   localparam logic [CW-1:0] DW_C = CW'(DW);

   logic [DW-1:0]   acc_q;
   logic [XLEN-1:0] rem_q;
   logic [XLEN-1:0] dsr_q;
   logic [CW-1:0]   cnt_q;
   logic [CW-1:0]   shamt;
   logic [XLEN:0]   trial;
   logic [XLEN:0]   diff;
   logic            ge;

   assign shamt = DW_C - iters_i;
   assign trial = {rem_q, acc_q[DW-1]};
   assign diff  = trial - {1'b0, dsr_q};
   assign ge    = (trial >= {1'b0, dsr_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         rem_q  <= '0;
         dsr_q  <= '0;
         cnt_q  <= '0;
         busy_o <= 1'b0;
         fin_o  <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         if (load_i) begin
            acc_q  <= dvd_i << shamt;
            rem_q  <= '0;
            dsr_q  <= dsr_i;
            cnt_q  <= iters_i;
            busy_o <= 1'b1;
         end else if (busy_o) begin
            acc_q <= {acc_q[DW-2:0], ge};
            rem_q <= ge ? diff[XLEN-1:0] : trial[XLEN-1:0];
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy_o <= 1'b0;
               fin_o  <= 1'b1;
            end
         end
      end
   end

   assign quo_o = acc_q;
   assign rem_o = rem_q;

endmodule

// File: rtl/intdiv_post.sv
module intdiv_post
   import intdiv_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  div_ctx_t          ctx_i,
   input  logic [2*XLEN-1:0] quo_i,
   input  logic [XLEN-1:0]   rem_i,
   output logic [XLEN-1:0]   result_o,
   output logic              ovf_o
);
   localparam int DW = 2 * XLEN;
   localparam int HW = XLEN / 2;
   localparam logic [DW-1:0] LIM_W = DW'(1) << (HW - 1);
   localparam logic [DW-1:0] LIM_D = DW'(1) << (XLEN - 1);

   logic            qneg;
   logic            rneg;
   logic [DW-1:0]   lim_s;
   logic [DW-1:0]   lim_u;
   logic            too_big;
   logic [DW-1:0]   qv;
   logic [XLEN-1:0] rv;
   logic [XLEN-1:0] val;

   assign qneg  = ctx_i.dvd_neg ^ ctx_i.dsr_neg;
   assign rneg  = ctx_i.dvd_neg;
   assign lim_s = ctx_i.op.dw ? LIM_D : LIM_W;
   assign lim_u = lim_s << 1;

   always_comb begin
      if (ctx_i.op.uns)
         too_big = (quo_i >= lim_u);
      else if (qneg)
         too_big = (quo_i > lim_s);
      else
         too_big = (quo_i >= lim_s);
   end

   assign qv = qneg ? (~quo_i + 1'b1) : quo_i;
   assign rv = rneg ? (~rem_i + 1'b1) : rem_i;

   always_comb begin
      if (ctx_i.op.md) begin
         if (ctx_i.op.dw)
            val = rv;
         else
            val = {{HW{~ctx_i.op.uns & rv[HW-1]}}, rv[HW-1:0]};
      end else begin
         if (ctx_i.op.dw)
            val = qv[XLEN-1:0];
         else
            val = {{HW{1'b0}}, qv[HW-1:0]};
      end
   end

   assign ovf_o    = ctx_i.dsr_zero | too_big;
   assign result_o = ovf_o ? '0 : val;

endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
   import intdiv_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [3:0]      op_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic            done_o,
   output logic [XLEN-1:0] result_o,
   output logic            ovf_o
);
   localparam int DW = 2 * XLEN;
   localparam int CW = $clog2(DW + 1);

   generate
      if ((XLEN % 2) != 0 || XLEN < 8) begin : g_bad_xlen
         $error("intdiv_unit: XLEN must be even and at least 8");
      end
   endgenerate

   div_op_t         op_dec;
   div_ctx_t        ctx_q;
   div_ctx_t        ctx_d;
   logic [DW-1:0]   dvd_mag;
   logic [XLEN-1:0] dsr_mag;
   logic            dvd_neg;
   logic            dsr_neg;
   logic            dsr_zero;
   logic [CW-1:0]   iters;
   logic            core_busy;
   logic            core_fin;
   logic [DW-1:0]   quo;
   logic [XLEN-1:0] rem;
   logic [XLEN-1:0] post_res;
   logic            post_ovf;
   logic            accept;

   assign op_dec = decode_op(op_i);
   assign accept = start_i & ~core_busy & ~core_fin;

   intdiv_prep #(.XLEN(XLEN)) u_prep (
      .op_i       (op_dec),
      .a_i        (a_i),
      .b_i        (b_i),
      .dvd_mag_o  (dvd_mag),
      .dsr_mag_o  (dsr_mag),
      .dvd_neg_o  (dvd_neg),
      .dsr_neg_o  (dsr_neg),
      .dsr_zero_o (dsr_zero),
      .iters_o    (iters)
   );

   intdiv_core #(.XLEN(XLEN)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .iters_i (iters),
      .dvd_i   (dvd_mag),
      .dsr_i   (dsr_mag),
      .busy_o  (core_busy),
      .fin_o   (core_fin),
      .quo_o   (quo),
      .rem_o   (rem)
   );

   always_comb begin
      ctx_d.op       = op_dec;
      ctx_d.dvd_neg  = dvd_neg;
      ctx_d.dsr_neg  = dsr_neg;
      ctx_d.dsr_zero = dsr_zero;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctx_q <= '0;
      else if (accept)
         ctx_q <= ctx_d;
   end

   intdiv_post #(.XLEN(XLEN)) u_post (
      .ctx_i    (ctx_q),
      .quo_i    (quo),
      .rem_i    (rem),
      .result_o (post_res),
      .ovf_o    (post_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o   <= 1'b0;
         result_o <= '0;
         ovf_o    <= 1'b0;
      end else begin
         done_o <= core_fin;
         if (core_fin) begin
            result_o <= post_res;
            ovf_o    <= post_ovf;
         end
      end
   end

endmodule

// File: rtl/intdiv_unit_chk.sv
module intdiv_unit_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            accept,
   input logic [3:0]      op_i,
   input logic            done_o,
   input logic [XLEN-1:0] result_o,
   input logic            ovf_o
);
   localparam int HW = XLEN / 2;

   logic       running;
   logic [8:0] cyc;
   logic [8:0] want;
   logic       lat_dw;
   logic       lat_ext;
   logic       lat_md;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cyc     <= '0;
         lat_dw  <= 1'b0;
         lat_ext <= 1'b0;
         lat_md  <= 1'b0;
      end else begin
         if (accept) begin
            running <= 1'b1;
            cyc     <= '0;
            lat_dw  <= op_i[1];
            lat_ext <= op_i[3];
            lat_md  <= op_i[2] & ~op_i[3];
         end else begin
            if (running) cyc <= cyc + 1'b1;
            if (done_o) running <= 1'b0;
         end
      end
   end

   assign want = (lat_ext && lat_dw) ? 9'(2*XLEN + 1) :
                 (lat_ext || lat_dw) ? 9'(XLEN + 1) : 9'(HW + 1);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (running && cyc == want));

   // R4
   ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ovf_o) |-> (result_o == '0));

   // R1
   word_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !ovf_o && !lat_dw && !lat_md) |-> (result_o[XLEN-1:HW] == '0));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(result_o) && $stable(ovf_o)));

   // R9
   no_reaccept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !accept);

endmodule

bind intdiv_unit intdiv_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .accept   (accept),
   .op_i     (op_i),
   .done_o   (done_o),
   .result_o (result_o),
   .ovf_o    (ovf_o)
);

// File: tb/intdiv_unit_bench.sv
module intdiv_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  op = 4'h0;
   logic [63:0] a = '0;
   logic [63:0] b = '0;
   logic        done;
   logic [63:0] result;
   logic        ovf;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   intdiv_unit u_intdiv_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .op_i     (op),
      .a_i      (a),
      .b_i      (b),
      .done_o   (done),
      .result_o (result),
      .ovf_o    (ovf)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic check(input bit ok, input string what,
                        input logic [64:0] act, input logic [64:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   // exact model: returns {ovf, result}
   function automatic logic [64:0] model(input logic [3:0] c, input logic [63:0] x,
                                         input logic [63:0] y);
      logic uns, dw, md, ext;
      int w;
      logic [129:0] ud, us, uq, ur;
      logic signed [129:0] sd, ss, sq, sr, lim;
      logic [63:0] r;
      uns = c[0]; dw = c[1]; ext = c[3]; md = c[2] & ~c[3];
      w = dw ? 64 : 32;
      if (uns) begin
         if (ext && dw) ud = {2'b0, x, 64'h0};
         else if (ext) ud = {66'h0, x[31:0], 32'h0};
         else if (dw) ud = {66'h0, x};
         else ud = {98'h0, x[31:0]};
         if (dw) us = {66'h0, y};
         else us = {98'h0, y[31:0]};
         if (us == 0) return {1'b1, 64'h0};
         uq = ud / us;
         ur = ud % us;
         if (uq >= (130'h1 << w)) return {1'b1, 64'h0};
         r = md ? ur[63:0] : uq[63:0];
      end else begin
         if (ext && dw) sd = $signed({x, 64'h0});
         else if (ext) sd = $signed({x[31:0], 32'h0});
         else if (dw) sd = $signed(x);
         else sd = $signed(x[31:0]);
         if (dw) ss = $signed(y);
         else ss = $signed(y[31:0]);
         if (ss == 0) return {1'b1, 64'h0};
         sq = sd / ss;
         sr = sd % ss;
         lim = 130'sd1;
         lim = lim <<< (w - 1);
         if (sq >= lim || sq < -lim) return {1'b1, 64'h0};
         r = md ? sr[63:0] : sq[63:0];
      end
      if (!dw) begin
         if (md && !uns) r = {{32{r[31]}}, r[31:0]};
         else r = {32'h0, r[31:0]};
      end
      return {1'b0, r};
   endfunction

   function automatic string tag_of(input logic [3:0] c, input logic [63:0] y);
      if ((c[1] ? y : {32'h0, y[31:0]}) == 64'h0) return "R4";
      if (c[3] && c[1]) return "R7";
      if (c[3]) return "R6";
      if (c[1]) return "R3";
      if (c[2]) return "R2";
      return "R1";
   endfunction

   task automatic run_op(input logic [3:0] c, input logic [63:0] x, input logic [63:0] y,
                         input string tag, input bit poke);
      logic [64:0] exp;
      logic [64:0] held;
      int lat;
      int n;
      exp = model(c, x, y);
      n = c[3] ? (c[1] ? 128 : 64) : (c[1] ? 64 : 32);
      @(negedge clk);
      start = 1'b1; op = c; a = x; b = y;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0; op = ~c; a = ~x; b = y ^ 64'h5;
      lat = 0;
      while (!done && lat < 400) begin
         @(posedge clk);
         @(negedge clk);
         lat++;
         if (poke && lat == 3) begin start = 1'b1; a = 64'h1; b = 64'h1; op = 4'h0; end
         if (poke && lat == 5) start = 1'b0;
      end
      // R8: completion latency
      check(lat == n + 1, {tag, " R8 latency"}, 65'(lat), 65'(n + 1));
      check({ovf, result} == exp, {tag, " result/ovf"}, {ovf, result}, exp);
      @(negedge clk);
      check(!done, "R8 done single cycle", {64'h0, done}, 65'h0);
      if (poke) begin
         // R9: a start during the run must not have been accepted
         held = {ovf, result};
         for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (done || {ovf, result} != held) break;
         end
         check(!done && {ovf, result} == held, "R9 start while busy ignored",
               {ovf, result}, held);
      end
   endtask

   initial begin
      logic [3:0] c;
      logic [63:0] x, y;
      int mode;
      void'($urandom(32'h51D3_0A77));
      #45;
      // R10: reset state
      check(done == 1'b0 && result == 64'h0 && ovf == 1'b0, "R10 reset outputs",
            {ovf, result}, 65'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && result == 64'h0 && ovf == 1'b0, "R10 after release",
            {ovf, result}, 65'h0);

      // R1: signed word divide, truncation toward zero, upper half zero
      run_op(4'b0000, 64'hDEAD_0000_0000_0007, 64'h1234_5678_FFFF_FFFE, "R1", 1'b0);
      run_op(4'b0000, 64'h0000_0000_FFFF_FFF9, 64'h0000_0000_0000_0002, "R1", 1'b0);
      run_op(4'b0001, 64'h0000_0000_FFFF_FFF9, 64'h0000_0000_0000_0002, "R1", 1'b0);
      // R2: remainder signs and word extension
      run_op(4'b0100, 64'h0000_0000_FFFF_FFF9, 64'h0000_0000_0000_0002, "R2", 1'b0);
      run_op(4'b0100, 64'h0000_0000_0000_0007, 64'h0000_0000_FFFF_FFFD, "R2", 1'b0);
      run_op(4'b0101, 64'h0000_0000_FFFF_FFF9, 64'h0000_0000_0000_0010, "R2", 1'b0);
      // R3: doubleword
      run_op(4'b0010, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0003, "R3", 1'b0);
      run_op(4'b0111, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0000, "R3", 1'b0);
      // R4: zero divisor
      run_op(4'b0000, 64'h5, 64'hFFFF_FFFF_0000_0000, "R4", 1'b0);
      run_op(4'b0111, 64'h5, 64'h0, "R4", 1'b0);
      run_op(4'b1011, 64'h5, 64'h0, "R4", 1'b0);
      // R5: most negative by minus one
      run_op(4'b0000, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R5", 1'b0);
      run_op(4'b0100, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R5", 1'b0);
      run_op(4'b0010, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R5", 1'b0);
      run_op(4'b0110, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R5", 1'b0);
      // R6: extended word, fit edges (bit 2 ignored when bit 3 set)
      run_op(4'b1001, 64'h0000_0000_0000_0004, 64'h0000_0000_0000_0005, "R6", 1'b0);
      run_op(4'b1101, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005, "R6", 1'b0);
      run_op(4'b1000, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, "R6", 1'b0);
      run_op(4'b1000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, "R6", 1'b0);
      run_op(4'b1000, 64'h0000_0000_0000_0001, 64'h0000_0000_FFFF_FFFE, "R6", 1'b0);
      // R7: extended doubleword
      run_op(4'b1011, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0007, "R7", 1'b0);
      run_op(4'b1010, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, "R7", 1'b0);
      run_op(4'b1010, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, "R7", 1'b0);
      // R9: start pulses during a run
      run_op(4'b0010, 64'h0000_0123_4567_89AB, 64'h0000_0000_0000_0011, "R9", 1'b1);
      run_op(4'b1011, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0009, "R9", 1'b1);

      // random mix
      for (int k = 0; k < 600; k++) begin
         c = 4'($urandom_range(0, 15));
         mode = $urandom_range(0, 5);
         x = {$urandom, $urandom};
         y = {$urandom, $urandom};
         case (mode)
            1: begin x = 64'($signed(16'($urandom))); y = 64'($signed(8'($urandom))); end
            2: y = c[1] ? 64'h0 : {$urandom, 32'h0};
            3: begin x = y >> $urandom_range(1, 40); if ($urandom_range(0, 1) == 1) x = ~x; end
            4: begin x = {32'h0, 32'($urandom_range(0, 1000))}; y = {32'h0, 32'($urandom_range(1, 1000))}; end
            default: ;
         endcase
         run_op(c, x, y, tag_of(c, y), 1'b0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule